// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block keeps the stack pointer of a small 8-bit processor core and turns stack commands into byte accesses on a data SRAM port. The decoder issues one command per cycle:
- push a data byte
- pop a data byte
- push a 16-bit return address for a call or an interrupt
- pop a 16-bit return address for a return

The stack grows toward lower addresses. A push stores at the current pointer and then moves the pointer down. A pop moves the pointer up and then reads at the new location.

The pointer can also be read and written as two byte registers on a simple register bus, selected low or high. Small data spaces can leave out the high byte with a parameter. In that configuration the high byte reads as zero and writes to it are dropped. The block raises a flag whenever a push is accepted while the pointer sits at or below the stack floor (0x60 by default). Software is expected to set the pointer above that floor before any call or interrupt.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer equals the TOP_ADDR parameter (0x025F by default). In that state `busy`, `pop_valid`, `ret_valid`, `mem_we` and `mem_re` are all low.
- R2: An accepted byte push (`cmd_op`=0) writes `cmd_wdata` at the current pointer address in the same cycle, and the pointer decreases by one.
- R3: An accepted byte pop (`cmd_op`=1) reads at pointer+1 in the same cycle, and the pointer increases by one. In the next cycle `pop_data` holds the byte read and `pop_valid` is high for one cycle.
- R4: An accepted return-address push (`cmd_op`=2) takes two cycles.
  - First cycle: bits 7:0 are written at the pointer.
  - Second cycle: `busy` is high and bits 15:8 are written at the pointer minus one.
  - The pointer ends two lower.
- R5: An accepted return-address pop (`cmd_op`=3) takes two cycles.
  - First cycle: it reads the high byte at pointer+1.
  - Second cycle: `busy` is high and it reads the low byte at pointer+2.
  - The pointer ends two higher, and the next cycle shows `ret_addr` with `ret_valid` high for one cycle.
- R6: A command presented while `busy` is high is ignored. It causes no memory access, no pointer change and no flag.
- R7: The register bus works as follows.
  - `reg_sel`=0 selects the pointer's low byte and `reg_sel`=1 selects its high byte.
  - `reg_rdata` shows the selected byte in the same cycle.
  - A write with `reg_we` changes only the selected byte.
  - A write is dropped when `busy` is high or when a command is accepted in the same cycle.
- R8: With HAS_HIGH=0 (pointer width 8), reading the high byte returns 0x00, and a write to it leaves the pointer unchanged.
- R9: `sp_low_flag` is high exactly in a cycle that accepts a push (`cmd_op` 0 or 2) while the pointer is at or below STACK_FLOOR (0x60). The flag is low for a pointer of 0x61 and above, and for pops.
- R10: Pointer arithmetic wraps modulo 2^PTR_W:
  - a pop at 0xFFFF reads address 0x0000;
  - a push at 0x0000 leaves the pointer at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request this cycle |
| cmd_op | input | 2 | 0 byte push, 1 byte pop, 2 return push, 3 return pop |
| cmd_wdata | input | 8 | Byte to push |
| cmd_ret_addr | input | 16 | Return address to push |
| busy | output | 1 | Second cycle of a two-cycle operation |
| sp_low_flag | output | 1 | Push accepted with pointer at or below the floor |
| pop_valid | output | 1 | One-cycle strobe for pop_data |
| pop_data | output | 8 | Byte returned by a byte pop |
| ret_valid | output | 1 | One-cycle strobe for ret_addr |
| ret_addr | output | 16 | Return address assembled by a return pop |
| mem_addr | output | PTR_W | SRAM address |
| mem_we | output | 1 | SRAM write enable |
| mem_wdata | output | 8 | SRAM write data |
| mem_re | output | 1 | SRAM read strobe |
| mem_rdata | input | 8 | SRAM read data, same cycle as the address |
| reg_we | input | 1 | Register-bus write |
| reg_sel | input | 1 | 0 low byte, 1 high byte |
| reg_wdata | input | 8 | Register-bus write data |
| reg_rdata | output | 8 | Selected pointer byte |
| sp_out | output | PTR_W | Current pointer value |

## Verification
The bench pushes a return address and pops it back, which exposes a byte-order error: a design that swapped the bytes would return 0x3412 for 0x1234, or would read the low byte at the wrong slot. It also issues commands and register writes during the busy cycle. A design that accepted those would corrupt the pointer by one or write an extra byte into the stack. The floor flag is probed on both sides of 0x60, so an off-by-one comparison shows up as a flag at 0x61 or a missing flag at 0x60. Pointer values 0xFFFF and 0x0000 test wrap-around: a saturating or widened adder would read the wrong address. A second instance without a high byte checks that writes to the missing byte cannot leak into the pointer.

// File: rtl/sp_pkg.sv
package sp_pkg;
   localparam int BYTE_W = 8;
   localparam int RA_W   = 2 * BYTE_W;

   typedef enum logic [1:0] {
      OP_PUSH_B  = 2'd0,
      OP_POP_B   = 2'd1,
      OP_PUSH_RA = 2'd2,
      OP_POP_RA  = 2'd3
   } sp_op_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PUSH_HI = 2'd1,
      ST_POP_LO  = 2'd2
   } sp_state_e;
endpackage

// File: rtl/sp_pointer.sv
module sp_pointer #(
   parameter int          PTR_W    = 16,
   parameter bit          HAS_HIGH = 1'b1,
   parameter logic [15:0] TOP_ADDR = 16'h025F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_dec,
   input  logic             step_inc,
   input  logic             op_active,
   input  logic             reg_we,
   input  logic             reg_sel,
   input  logic [7:0]       reg_wdata,
   output logic [PTR_W-1:0] sp,
   output logic [7:0]       reg_rdata
);
   logic [PTR_W-1:0] sp_q;
   logic [PTR_W-1:0] lo_wr;
   logic [PTR_W-1:0] hi_wr;
   logic [7:0]       hi_rd;
   logic             wr_ok;

   generate
      if (HAS_HIGH) begin : g_two_byte
         assign lo_wr = {sp_q[PTR_W-1:8], reg_wdata};
         assign hi_wr = PTR_W'({reg_wdata, sp_q[7:0]});
         assign hi_rd = 8'(sp_q >> 8);
      end else begin : g_one_byte
         assign lo_wr = PTR_W'(reg_wdata);
         assign hi_wr = sp_q;
         assign hi_rd = '0;
      end
   endgenerate

   assign wr_ok = reg_we && !op_active;

   always_ff @(posedge clk) begin
      if (!rst_n)          sp_q <= PTR_W'(TOP_ADDR);
      else if (step_dec)   sp_q <= sp_q - 1'b1;
      else if (step_inc)   sp_q <= sp_q + 1'b1;
      else if (wr_ok)      sp_q <= reg_sel ? hi_wr : lo_wr;
   end

   assign sp        = sp_q;
   assign reg_rdata = reg_sel ? hi_rd : sp_q[7:0];
endmodule

// File: rtl/sp_sequencer.sv
module sp_sequencer
   import sp_pkg::*;
#(
   parameter int          PTR_W       = 16,
   parameter logic [15:0] STACK_FLOOR = 16'h0060
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [BYTE_W-1:0] cmd_wdata,
   input  logic [RA_W-1:0]   cmd_ret_addr,
   input  logic [PTR_W-1:0]  sp,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              busy,
   output logic              accept,
   output logic              step_dec,
   output logic              step_inc,
   output logic              low_flag,
   output logic [PTR_W-1:0]  mem_addr,
   output logic              mem_we,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              mem_re,
   output logic              pop_valid,
   output logic [BYTE_W-1:0] pop_data,
   output logic              ret_valid,
   output logic [RA_W-1:0]   ret_addr
);
   sp_state_e         state_q;
   sp_op_e            op;
   logic [BYTE_W-1:0] hold_q;
   logic [PTR_W-1:0]  sp_up;
   logic              at_floor;

   assign op       = sp_op_e'(cmd_op);
   assign busy     = (state_q != ST_IDLE);
   assign accept   = cmd_valid && (state_q == ST_IDLE);
   assign sp_up    = sp + 1'b1;
   assign at_floor = (sp <= PTR_W'(STACK_FLOOR));

   always_comb begin
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_addr  = sp;
      mem_wdata = '0;
      step_dec  = 1'b0;
      step_inc  = 1'b0;
      low_flag  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               unique case (op)
                  OP_PUSH_B, OP_PUSH_RA: begin
                     mem_we    = 1'b1;
                     mem_wdata = (op == OP_PUSH_B) ? cmd_wdata
                                                   : cmd_ret_addr[BYTE_W-1:0];
                     step_dec  = 1'b1;
                     low_flag  = at_floor;
                  end
                  OP_POP_B, OP_POP_RA: begin
                     mem_re   = 1'b1;
                     mem_addr = sp_up;
                     step_inc = 1'b1;
                  end
                  default: ;
               endcase
            end
         end
         ST_PUSH_HI: begin
            mem_we    = 1'b1;
            mem_wdata = hold_q;
            step_dec  = 1'b1;
         end
         ST_POP_LO: begin
            mem_re   = 1'b1;
            mem_addr = sp_up;
            step_inc = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         hold_q    <= '0;
         pop_valid <= 1'b0;
         pop_data  <= '0;
         ret_valid <= 1'b0;
         ret_addr  <= '0;
      end else begin
         pop_valid <= 1'b0;
         ret_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  unique case (op)
                     OP_POP_B: begin
                        pop_data  <= mem_rdata;
                        pop_valid <= 1'b1;
                     end
                     OP_PUSH_RA: begin
                        hold_q  <= cmd_ret_addr[RA_W-1:BYTE_W];
                        state_q <= ST_PUSH_HI;
                     end
                     OP_POP_RA: begin
                        hold_q  <= mem_rdata;
                        state_q <= ST_POP_LO;
                     end
                     default: ;
                  endcase
               end
            end
            ST_PUSH_HI: state_q <= ST_IDLE;
            ST_POP_LO: begin
               ret_addr  <= {hold_q, mem_rdata};
               ret_valid <= 1'b1;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
   import sp_pkg::*;
#(
   parameter int          PTR_W       = 16,
   parameter bit          HAS_HIGH    = 1'b1,
   parameter logic [15:0] TOP_ADDR    = 16'h025F,
   parameter logic [15:0] STACK_FLOOR = 16'h0060
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [7:0]        cmd_wdata,
   input  logic [15:0]       cmd_ret_addr,
   output logic              busy,
   output logic              sp_low_flag,
   output logic              pop_valid,
   output logic [7:0]        pop_data,
   output logic              ret_valid,
   output logic [15:0]       ret_addr,
   output logic [PTR_W-1:0]  mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   output logic              mem_re,
   input  logic [7:0]        mem_rdata,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [PTR_W-1:0]  sp_out
);
   localparam int MAX_W = 2 * BYTE_W;

   generate
      if (HAS_HIGH && (PTR_W <= BYTE_W || PTR_W > MAX_W)) begin : g_bad_wide
         $error("stack_ptr_unit: with a high byte PTR_W must be 9..16");
      end
      if (!HAS_HIGH && PTR_W != BYTE_W) begin : g_bad_narrow
         $error("stack_ptr_unit: without a high byte PTR_W must be 8");
      end
      if (32'(TOP_ADDR) >= (32'd1 << PTR_W)) begin : g_bad_top
         $error("stack_ptr_unit: TOP_ADDR exceeds pointer width");
      end
   endgenerate

   logic             accept;
   logic             step_dec;
   logic             step_inc;
   logic [PTR_W-1:0] sp;

   sp_sequencer #(
      .PTR_W       (PTR_W),
      .STACK_FLOOR (STACK_FLOOR)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_op       (cmd_op),
      .cmd_wdata    (cmd_wdata),
      .cmd_ret_addr (cmd_ret_addr),
      .sp           (sp),
      .mem_rdata    (mem_rdata),
      .busy         (busy),
      .accept       (accept),
      .step_dec     (step_dec),
      .step_inc     (step_inc),
      .low_flag     (sp_low_flag),
      .mem_addr     (mem_addr),
      .mem_we       (mem_we),
      .mem_wdata    (mem_wdata),
      .mem_re       (mem_re),
      .pop_valid    (pop_valid),
      .pop_data     (pop_data),
      .ret_valid    (ret_valid),
      .ret_addr     (ret_addr)
   );

   sp_pointer #(
      .PTR_W    (PTR_W),
      .HAS_HIGH (HAS_HIGH),
      .TOP_ADDR (TOP_ADDR)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_dec  (step_dec),
      .step_inc  (step_inc),
      .op_active (busy | accept),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .sp        (sp),
      .reg_rdata (reg_rdata)
   );

   assign sp_out = sp;
endmodule

// File: rtl/sp_unit_checks.sv
module sp_unit_checks
   import sp_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [1:0]       cmd_op,
   input logic             busy,
   input logic             sp_low_flag,
   input logic             pop_valid,
   input logic             ret_valid,
   input logic [PTR_W-1:0] mem_addr,
   input logic             mem_we,
   input logic             mem_re,
   input logic [PTR_W-1:0] sp_out
);
   // R2
   a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_op == OP_PUSH_B)
      |=> (sp_out == PTR_W'($past(sp_out) - 1'b1)));

   // R3
   a_r3_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_op == OP_POP_B)
      |=> (pop_valid && sp_out == PTR_W'($past(sp_out) + 1'b1)));

   // R4
   a_r4_high_below_low: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_we) |-> (mem_addr == PTR_W'($past(mem_addr) - 1'b1)));

   // R5
   a_r5_ret_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_re) |=> ret_valid);

   a_r5_ret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |=> !ret_valid);

   // R6
   a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   a_r6_busy_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_we) |=> (sp_out == PTR_W'($past(sp_out) - 1'b1)));

   // R9
   a_r9_flag_on_push: assert property (@(posedge clk) disable iff (!rst_n)
      sp_low_flag |-> (mem_we && !busy));

   a_r9_no_dual_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
endmodule

bind stack_ptr_unit sp_unit_checks #(.PTR_W(PTR_W)) u_checks (.*);

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [7:0]  cmd_wdata = 8'd0;
   logic [15:0] cmd_ret_addr = 16'd0;
   logic        reg_we = 1'b0, reg_sel = 1'b0;
   logic [7:0]  reg_wdata = 8'd0;
   logic        busy, sp_low_flag, pop_valid, ret_valid, mem_we, mem_re;
   logic [7:0]  pop_data, mem_wdata, mem_rdata, reg_rdata;
   logic [15:0] ret_addr, mem_addr, sp_out;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   stack_ptr_unit dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_wdata(cmd_wdata), .cmd_ret_addr(cmd_ret_addr), .busy(busy),
      .sp_low_flag(sp_low_flag), .pop_valid(pop_valid), .pop_data(pop_data),
      .ret_valid(ret_valid), .ret_addr(ret_addr), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sp_out(sp_out));

   // behavioural SRAM, 1 KiB aliased
   logic [7:0] ram [0:1023];
   initial for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
   always @(posedge clk) if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
   assign mem_rdata = ram[mem_addr[9:0]];

   // narrow instance without a high byte
   logic        c8_valid = 1'b0;
   logic [1:0]  c8_op = 2'd0;
   logic        r8_we = 1'b0, r8_sel = 1'b0;
   logic [7:0]  r8_wdata = 8'd0;
   logic        b8, f8, pv8, rv8, we8, re8;
   logic [7:0]  pd8, wd8, rd8, a8, sp8;
   logic [15:0] ra8;

   stack_ptr_unit #(.PTR_W(8), .HAS_HIGH(1'b0), .TOP_ADDR(16'h00F0)) dut8 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(c8_valid), .cmd_op(c8_op),
      .cmd_wdata(8'h33), .cmd_ret_addr(16'h0000), .busy(b8),
      .sp_low_flag(f8), .pop_valid(pv8), .pop_data(pd8),
      .ret_valid(rv8), .ret_addr(ra8), .mem_addr(a8),
      .mem_we(we8), .mem_wdata(wd8), .mem_re(re8),
      .mem_rdata(8'h5A), .reg_we(r8_we), .reg_sel(r8_sel),
      .reg_wdata(r8_wdata), .reg_rdata(rd8), .sp_out(sp8));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // reference model state
   int m_sp, m_state, m_hold;
   bit e_pv, e_rv;
   int e_pd, e_ra;
   logic [7:0] mm [0:1023];
   initial for (int i = 0; i < 1024; i++) mm[i] = 8'h00;

   always @(negedge clk) begin
      #2;
      if (!rst_n) begin
         m_sp = 16'h025F; m_state = 0; m_hold = 0;
         e_pv = 0; e_rv = 0; e_pd = 0; e_ra = 0;
      end else begin
         bit acc, x_we, x_re, x_fl;
         int x_addr, x_wd, n_sp, n_st;
         acc = cmd_valid && m_state == 0;
         x_we = 0; x_re = 0; x_fl = 0; x_addr = m_sp; x_wd = 0;
         n_sp = m_sp; n_st = m_state;
         // registered outputs predicted last cycle (R1 R3 R5)
         check(pop_valid == e_pv, "R3", "pop_valid", pop_valid, e_pv);
         if (e_pv) check(pop_data == e_pd[7:0], "R3", "pop_data", pop_data, e_pd);
         check(ret_valid == e_rv, "R5", "ret_valid", ret_valid, e_rv);
         if (e_rv) check(ret_addr == e_ra[15:0], "R5", "ret_addr", ret_addr, e_ra);
         check(sp_out == m_sp[15:0], "R1", "sp_out", sp_out, m_sp);
         check(busy == (m_state != 0), "R6", "busy", busy, m_state != 0);
         check(reg_rdata == (reg_sel ? m_sp[15:8] : m_sp[7:0]), "R7", "reg_rdata",
               reg_rdata, reg_sel ? m_sp[15:8] : m_sp[7:0]);
         e_pv = 0; e_rv = 0;
         case (m_state)
            0: if (acc) begin
               case (cmd_op)
                  2'd0, 2'd2: begin
                     x_we = 1; x_addr = m_sp;
                     x_wd = (cmd_op == 2'd0) ? cmd_wdata : cmd_ret_addr[7:0];
                     x_fl = (m_sp <= 16'h60);
                     n_sp = (m_sp - 1) & 16'hFFFF;
                     if (cmd_op == 2'd2) begin m_hold = cmd_ret_addr[15:8]; n_st = 1; end
                  end
                  default: begin
                     x_re = 1; x_addr = (m_sp + 1) & 16'hFFFF;
                     n_sp = x_addr;
                     if (cmd_op == 2'd1) begin e_pv = 1; e_pd = mm[x_addr % 1024]; end
                     else begin m_hold = mm[x_addr % 1024]; n_st = 2; end
                  end
               endcase
            end else if (reg_we) begin
               if (reg_sel) n_sp = {reg_wdata, m_sp[7:0]};
               else         n_sp = {m_sp[15:8], reg_wdata};
            end
            1: begin
               x_we = 1; x_addr = m_sp; x_wd = m_hold;
               n_sp = (m_sp - 1) & 16'hFFFF; n_st = 0;
            end
            default: begin
               x_re = 1; x_addr = (m_sp + 1) & 16'hFFFF; n_sp = x_addr;
               e_rv = 1; e_ra = {m_hold[7:0], mm[x_addr % 1024]}; n_st = 0;
            end
         endcase
         check(mem_we == x_we, "R2", "mem_we", mem_we, x_we);
         check(mem_re == x_re, "R3", "mem_re", mem_re, x_re);
         check(sp_low_flag == x_fl, "R9", "sp_low_flag", sp_low_flag, x_fl);
         if (x_we) begin
            check(mem_addr == x_addr[15:0], "R4", "write addr", mem_addr, x_addr);
            check(mem_wdata == x_wd[7:0], "R2", "write data", mem_wdata, x_wd);
            mm[x_addr % 1024] = x_wd[7:0];
         end
         if (x_re) check(mem_addr == x_addr[15:0], "R10", "read addr", mem_addr, x_addr);
         m_sp = n_sp; m_state = n_st;
      end
   end

   task automatic drive(input bit v, input int op, input int wd, input int ra,
                        input bit rw, input bit rs, input int rd);
      @(negedge clk);
      cmd_valid = v; cmd_op = op[1:0]; cmd_wdata = wd[7:0]; cmd_ret_addr = ra[15:0];
      reg_we = rw; reg_sel = rs; reg_wdata = rd[7:0];
   endtask
   task automatic idle();             drive(0, 0, 0, 0, 0, 0, 0); endtask
   task automatic cmd(input int op, input int wd, input int ra); drive(1, op, wd, ra, 0, 0, 0); endtask
   task automatic regw(input bit s, input int d); drive(0, 0, 0, 0, 1, s, d); endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(); idle();
      // R2 R3: byte LIFO
      cmd(0, 8'hA1, 0); cmd(0, 8'hB2, 0); idle();
      cmd(1, 0, 0); cmd(1, 0, 0); idle(); idle();
      // R4 R6: return push, command and register write during busy dropped
      cmd(2, 0, 16'h1234); cmd(0, 8'hEE, 0); idle();
      cmd(2, 0, 16'hBEEF); regw(0, 8'h11); idle();
      // R5 R6: return pops, pop during busy dropped
      cmd(3, 0, 0); cmd(1, 0, 0); idle();
      cmd(3, 0, 0); idle(); idle();
      // R7: register reads and writes, write with same-cycle command dropped
      regw(0, 8'h61); regw(1, 8'h00); drive(0, 0, 0, 0, 0, 1, 0); idle();
      drive(1, 0, 8'h77, 0, 1, 0, 8'h99); idle();
      // R9: floor at 0x60
      regw(0, 8'h61); cmd(0, 8'h01, 0); cmd(0, 8'h02, 0); cmd(2, 0, 16'h0A0B);
      idle(); cmd(3, 0, 0); idle(); cmd(1, 0, 0); cmd(1, 0, 0); idle();
      // R10: wrap both ways
      regw(1, 8'hFF); regw(0, 8'hFF); cmd(1, 0, 0); cmd(0, 8'h3C, 0);
      cmd(1, 0, 0); cmd(2, 0, 16'hC0DE); idle(); cmd(3, 0, 0); idle(); idle();
      // R8: narrow instance
      @(negedge clk); r8_sel = 1'b1; #2;
      check(rd8 == 8'h00, "R8", "narrow high read", rd8, 0);
      r8_we = 1'b1; r8_wdata = 8'h12;
      @(negedge clk); r8_we = 1'b0; #2;
      check(rd8 == 8'h00, "R8", "narrow high after write", rd8, 0);
      check(sp8 == 8'hF0, "R8", "narrow pointer kept", sp8, 8'hF0);
      r8_sel = 1'b0; r8_we = 1'b1; r8_wdata = 8'h00;
      @(negedge clk); r8_we = 1'b0; c8_valid = 1'b1; c8_op = 2'd0; #2;
      check(we8 && a8 == 8'h00, "R10", "narrow push addr", a8, 0);
      check(f8 == 1'b1, "R9", "narrow floor flag", f8, 1);
      @(negedge clk); c8_op = 2'd1; #2;
      check(sp8 == 8'hFF, "R10", "narrow wrap down", sp8, 8'hFF);
      check(re8 && a8 == 8'h00, "R10", "narrow pop addr", a8, 0);
      @(negedge clk); c8_valid = 1'b0; #2;
      check(pv8 && pd8 == 8'h5A, "R3", "narrow pop data", pd8, 8'h5A);
      check(sp8 == 8'h00, "R10", "narrow wrap up", sp8, 0);
      idle(); idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule